// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the digital control for a 12-bit successive-approximation converter whose result leaves on a serial line. A host starts a frame with a falling edge on chip select, or with a falling edge on frame sync while chip select is held low. The block then does four things in turn. It drives the previous conversion result onto the data line, most significant bit first. It opens a 12-clock sampling window for the analog front end. Once the 16th serial clock has fallen, it runs the conversion for 14 conversion clocks, each two serial clocks long. It then returns to power-down until the next frame starts.

The serial clock, chip select and frame sync come from outside, so the block synchronises all three to its own clock and works on their edges. The result comes from a behavioural SAR core on `core_result_i`. The block takes that value when the conversion count runs out and shifts it out in the next frame. If the host raises chip select or frame sync while a frame is still in flight, the conversion is dropped. The block then returns to power-down and marks the following frame as invalid.

Top module: `adcf_frame_ctrl`

## Requirements
- R1: After reset the data output enable, sample enable, convert enable and invalid flag are low and the power-down flag is high.
- R2: With frame sync high, a falling edge on chip select starts a frame and enables the data line with the result MSB. A falling edge on frame sync while chip select is high starts nothing.
- R3: With chip select low, a falling edge on frame sync starts a frame. A falling edge on chip select while frame sync is already low also starts a frame.
- R4: The frame word is 16 bits, shifted MSB first. Word bits 15..4 hold the 12-bit result and bits 3..0 are zero. The MSB is held through the first serial clock fall, and each later bit appears on the serial clock rise that follows a fall.
- R5: The data output enable stays low between frames. It stays high through the 16th serial clock fall and drops on the 17th serial clock rise.
- R6: The sample enable rises after the 4th serial clock fall of the frame and stays high until the 16th fall, a window of 12 serial clocks.
- R7: The convert enable is high from the 16th serial clock fall for 28 further falls (14 conversion clocks). At the last of these falls, `core_result_i` is captured, and the next frame shifts out that value.
- R8: A rising chip select or frame sync edge during a frame aborts it. The block then drops the data enable, sample enable and convert enable, keeps the previous result and enters power-down.
- R9: The frame that follows an abort has the invalid flag high. The frame after that has it low again, unless a second abort has occurred.
- R10: The power-down flag rises when a conversion completes and falls when a frame starts.
- R11: The result is unipolar straight binary, passed through unchanged: code 000h gives an all-zero word, and code FFFh gives FFF0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, also the conversion time base |
| cs_ni | input | 1 | Chip select, active low |
| fs_ni | input | 1 | Frame sync; its falling edge starts a frame while chip select is low |
| core_result_i | input | 12 | Result from the SAR core, held stable until the conversion ends |
| sdo_o | output | 1 | Serial data, forced low while not enabled |
| sdo_oe_o | output | 1 | Output enable for the tri-state data line |
| sample_en_o | output | 1 | Sampling window for the analog front end |
| convert_en_o | output | 1 | Conversion in progress |
| pwrdn_o | output | 1 | Auto power-down state |
| frame_invalid_o | output | 1 | Current frame carries data from before an aborted conversion |

## Verification
A serial clock count that is off by one shows up in three places within a single frame. Frame words come out shifted by one position. The sample window opens one edge early or late. The data line releases at the wrong edge. The bench checks the enables between the edges where they change, so such a fault is caught at the first frame. A fault in result capture or abort handling shows only one frame later, as a wrong word or a wrong invalid flag. The scoreboard therefore carries the expected word and flag from each frame into the next one, and runs aborts both in the shift phase and in the conversion phase.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  typedef enum logic [1:0] {
    ST_PDN   = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CONV  = 2'd2
  } adcf_state_e;
endpackage

// File: rtl/adcf_edge_sync.sv
module adcf_edge_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RESET_VAL}};
      prev_q <= RESET_VAL;
    end else begin
      sync_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adcf_sequencer.sv
module adcf_sequencer
  import adcf_pkg::*;
#(
  parameter int unsigned RES_W         = 12,
  parameter int unsigned FRAME_BITS    = 16,
  parameter int unsigned SAMPLE_CLKS   = 12,
  parameter int unsigned CONV_CLKS     = 14,
  parameter int unsigned SCLK_PER_CONV = 2,
  localparam int unsigned FALL_W       = $clog2(FRAME_BITS + 1),
  localparam int unsigned CONV_SCLKS   = CONV_CLKS * SCLK_PER_CONV,
  localparam int unsigned CONV_W       = $clog2(CONV_SCLKS + 1),
  localparam int unsigned SAMPLE_START = FRAME_BITS - SAMPLE_CLKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_fall_i,
  input  logic              cs_lvl_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              fs_fall_i,
  input  logic              fs_rise_i,
  input  logic [RES_W-1:0]  core_result_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [FALL_W-1:0] fall_cnt_o,
  output logic [RES_W-1:0]  result_o,
  output logic              sample_en_o,
  output logic              convert_en_o,
  output logic              pwrdn_o,
  output logic              frame_invalid_o
);
  adcf_state_e       state_q;
  logic [FALL_W-1:0] fall_cnt_q;
  logic [CONV_W-1:0] conv_cnt_q;
  logic [RES_W-1:0]  result_q;
  logic              abort_pend_q;
  logic              invalid_q;

  // cs fall always starts; fs fall only when the chip is already selected
  assign start_o = (state_q == ST_PDN) & (cs_fall_i | (fs_fall_i & ~cs_lvl_i));
  assign abort_o = (state_q != ST_PDN) & (cs_rise_i | fs_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_PDN;
      fall_cnt_q   <= '0;
      conv_cnt_q   <= '0;
      result_q     <= '0;
      abort_pend_q <= 1'b0;
      invalid_q    <= 1'b0;
    end else if (start_o) begin
      state_q      <= ST_SHIFT;
      fall_cnt_q   <= '0;
      conv_cnt_q   <= '0;
      invalid_q    <= abort_pend_q;
      abort_pend_q <= 1'b0;
    end else if (abort_o) begin
      state_q      <= ST_PDN;
      abort_pend_q <= 1'b1;
    end else if (sclk_fall_i) begin
      unique case (state_q)
        ST_SHIFT: begin
          fall_cnt_q <= fall_cnt_q + 1'b1;
          if (fall_cnt_q == FALL_W'(FRAME_BITS - 1)) begin
            state_q    <= ST_CONV;
            conv_cnt_q <= '0;
          end
        end
        ST_CONV: begin
          conv_cnt_q <= conv_cnt_q + 1'b1;
          if (conv_cnt_q == CONV_W'(CONV_SCLKS - 1)) begin
            state_q  <= ST_PDN;
            result_q <= core_result_i;
          end
        end
        default: ;
      endcase
    end
  end

  assign fall_cnt_o      = fall_cnt_q;
  assign result_o        = result_q;
  assign sample_en_o     = (state_q == ST_SHIFT) && (fall_cnt_q >= FALL_W'(SAMPLE_START));
  assign convert_en_o    = (state_q == ST_CONV);
  assign pwrdn_o         = (state_q == ST_PDN);
  assign frame_invalid_o = invalid_q;

  AST_SAMPLE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_en_o) |-> $past(sclk_fall_i)); // R6
  AST_CONV_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convert_en_o) |-> $past(sample_en_o)); // R7
  AST_RESULT_ONLY_AT_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_q) |-> $past(convert_en_o) && pwrdn_o); // R7
  AST_ABORT_TO_PDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> pwrdn_o && !convert_en_o && !sample_en_o); // R8
  AST_INVALID_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_invalid_o) |-> $past(start_o)); // R9
  AST_WAKE_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwrdn_o) |-> $past(cs_fall_i || fs_fall_i)); // R10
endmodule

// File: rtl/adcf_shifter.sv
module adcf_shifter #(
  parameter int unsigned RES_W      = 12,
  parameter int unsigned FRAME_BITS = 16,
  localparam int unsigned FALL_W    = $clog2(FRAME_BITS + 1),
  localparam int unsigned PAD_W     = FRAME_BITS - RES_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              sclk_rise_i,
  input  logic [FALL_W-1:0] fall_cnt_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              sdo_o,
  output logic              oe_o
);
  logic [FRAME_BITS-1:0] sreg_q;
  logic                  oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      sreg_q <= {result_i, {PAD_W{1'b0}}};
      oe_q   <= 1'b1;
    end else if (abort_i) begin
      oe_q <= 1'b0;
    end else if (sclk_rise_i && oe_q) begin
      // release on the rise after the last fall; MSB holds until the first fall
      if (fall_cnt_i == FALL_W'(FRAME_BITS)) oe_q <= 1'b0;
      else if (fall_cnt_i != '0) sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sdo_o = oe_q & sreg_q[FRAME_BITS-1];
  assign oe_o  = oe_q;

  AST_OE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(start_i)); // R2
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && $past(oe_q) && !$past(sclk_rise_i) && !$past(start_i)) |-> $stable(sdo_o)); // R4
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> $past(sclk_rise_i || abort_i)); // R5
endmodule

// File: rtl/adcf_frame_ctrl.sv
module adcf_frame_ctrl #(
  parameter int unsigned RES_W         = 12,
  parameter int unsigned FRAME_BITS    = 16,
  parameter int unsigned SAMPLE_CLKS   = 12,
  parameter int unsigned CONV_CLKS     = 14,
  parameter int unsigned SCLK_PER_CONV = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             fs_ni,
  input  logic [RES_W-1:0] core_result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             sample_en_o,
  output logic             convert_en_o,
  output logic             pwrdn_o,
  output logic             frame_invalid_o
);
  localparam int unsigned FALL_W = $clog2(FRAME_BITS + 1);
  localparam int unsigned N_IN   = 3;
  localparam int unsigned IX_SCLK = 0;
  localparam int unsigned IX_CS   = 1;
  localparam int unsigned IX_FS   = 2;
  localparam logic [N_IN-1:0] IDLE_LVL = 3'b110;

  logic [N_IN-1:0] raw_in, lvl, rise, fall;
  assign raw_in = {fs_ni, cs_ni, sclk_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    adcf_edge_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(IDLE_LVL[g])
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in[g]),
      .lvl_o (lvl[g]),
      .rise_o(rise[g]),
      .fall_o(fall[g])
    );
  end

  logic unused_edges;
  assign unused_edges = ^{lvl[IX_SCLK], lvl[IX_FS]};

  logic              start, abort;
  logic [FALL_W-1:0] fall_cnt;
  logic [RES_W-1:0]  result;

  adcf_sequencer #(
    .RES_W        (RES_W),
    .FRAME_BITS   (FRAME_BITS),
    .SAMPLE_CLKS  (SAMPLE_CLKS),
    .CONV_CLKS    (CONV_CLKS),
    .SCLK_PER_CONV(SCLK_PER_CONV)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sclk_fall_i    (fall[IX_SCLK]),
    .cs_lvl_i       (lvl[IX_CS]),
    .cs_fall_i      (fall[IX_CS]),
    .cs_rise_i      (rise[IX_CS]),
    .fs_fall_i      (fall[IX_FS]),
    .fs_rise_i      (rise[IX_FS]),
    .core_result_i  (core_result_i),
    .start_o        (start),
    .abort_o        (abort),
    .fall_cnt_o     (fall_cnt),
    .result_o       (result),
    .sample_en_o    (sample_en_o),
    .convert_en_o   (convert_en_o),
    .pwrdn_o        (pwrdn_o),
    .frame_invalid_o(frame_invalid_o)
  );

  adcf_shifter #(
    .RES_W     (RES_W),
    .FRAME_BITS(FRAME_BITS)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (abort),
    .sclk_rise_i(rise[IX_SCLK]),
    .fall_cnt_i (fall_cnt),
    .result_i   (result),
    .sdo_o      (sdo_o),
    .oe_o       (sdo_oe_o)
  );

  AST_PDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_o |-> !sample_en_o && !convert_en_o); // R10
  AST_NO_DRIVE_WHILE_CONV_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwrdn_o) |-> !sdo_oe_o); // R5
endmodule

// File: tb/adcf_frame_ctrl_bench.sv
module adcf_frame_ctrl_bench;
  localparam int H = 8;           // clk cycles per serial clock half period
  localparam int TOTAL_FALLS = 44;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, fs_n = 1'b1;
  logic [11:0] core_res = '0;
  logic sdo, sdo_oe, smp, cnv, pdn, inv;

  always #2 clk = ~clk;

  adcf_frame_ctrl u_adcf_frame_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .fs_ni(fs_n),
    .core_result_i(core_res), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .sample_en_o(smp), .convert_en_o(cnv), .pwrdn_o(pdn), .frame_invalid_o(inv)
  );

  int n_chk = 0, n_bad = 0;
  logic [16:0] exp_q[$];          // {invalid, word}
  logic [15:0] cap_word, cap_mask;
  logic        cap_inv;
  logic [11:0] mdl_result = '0;
  logic        mdl_inv_next = 1'b0;
  event        frame_done;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(frame_done);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected frame", 0, 1);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk(((cap_word ^ e[15:0]) & cap_mask) == 16'h0, "R4/R7/R11", "frame word",
            cap_word & cap_mask, e[15:0] & cap_mask);
        chk(cap_inv == e[16], "R9", "invalid flag", cap_inv, e[16]);
      end
    end
  end

  // mode 0: cs fall with fs high; mode 1: fs fall with cs low; mode 2: fs low then cs fall
  task automatic run_frame(input int mode, input logic [11:0] code, input int abort_at);
    logic stop;
    stop = 1'b0;
    exp_q.push_back({mdl_inv_next, mdl_result, 4'h0});
    core_res = code;
    cap_word = '0; cap_mask = '0;
    if (mode == 0) begin
      cs_n = 1'b1; fs_n = 1'b1; wait_clk(H);
      cs_n = 1'b0;
    end else if (mode == 1) begin
      fs_n = 1'b1; wait_clk(H);
      fs_n = 1'b0;
    end else begin
      cs_n = 1'b1; fs_n = 1'b1; wait_clk(H);
      fs_n = 1'b0; wait_clk(H);
      chk(pdn && !sdo_oe, "R2", "fs fall with cs high ignored", {pdn, sdo_oe}, 2'b10);
      cs_n = 1'b0;
    end
    wait_clk(H);
    chk(sdo_oe, mode == 0 ? "R2" : "R3", "oe at frame start", sdo_oe, 1);
    chk(!pdn, "R10", "pwrdn low after start", pdn, 0);
    cap_inv = inv;
    for (int n = 1; n <= TOTAL_FALLS && !stop; n++) begin
      sclk = 1'b1; wait_clk(H);
      if (n <= 16) begin
        cap_word[16-n] = sdo;
        cap_mask[16-n] = 1'b1;
        if (!sdo_oe) chk(1'b0, "R5", "oe during frame", 0, 1);
      end
      if (n == 17) chk(!sdo_oe, "R5", "oe released at 17th rise", sdo_oe, 0);
      sclk = 1'b0; wait_clk(H);
      if (n == 3)  chk(!smp, "R6", "sample before 4th fall", smp, 0);
      if (n == 4)  chk(smp, "R6", "sample after 4th fall", smp, 1);
      if (n == 15) chk(smp && !cnv, "R6", "sample at 15th fall", {smp, cnv}, 2'b10);
      if (n == 16) chk(!smp && cnv && sdo_oe, "R7", "conv after 16th fall",
                       {smp, cnv, sdo_oe}, 3'b011);
      if (n == 43) chk(cnv && !pdn, "R7", "conv at 43rd fall", {cnv, pdn}, 2'b10);
      if (n == 44) chk(!cnv && pdn, "R10", "pwrdn at end of conv", {cnv, pdn}, 2'b01);
      if (n == abort_at) begin
        if (mode == 1) fs_n = 1'b1; else cs_n = 1'b1;
        wait_clk(H);
        chk(pdn && !cnv && !smp && !sdo_oe, "R8", "abort outputs",
            {pdn, cnv, smp, sdo_oe}, 4'b1000);
        stop = 1'b1;
      end
    end
    ->frame_done;
    wait_clk(2);
    if (abort_at == 0) begin
      mdl_result   = code;
      mdl_inv_next = 1'b0;
    end else begin
      mdl_inv_next = 1'b1;
    end
    if (mode == 0) begin cs_n = 1'b1; fs_n = 1'b1; end
    else begin fs_n = 1'b1; end
    wait_clk(H);
  endtask

  logic wd_hit = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    chk(!sdo_oe && !smp && !cnv && pdn && !inv, "R1", "reset state",
        {sdo_oe, smp, cnv, pdn, inv}, 5'b00010);
    rst_ni = 1'b1;
    wait_clk(5);
    chk(!sdo_oe && pdn && !sdo, "R1", "idle after reset", {sdo_oe, pdn, sdo}, 3'b010);

    run_frame(0, 12'hA5C, 0);   // R2 R4: shows reset result 0
    run_frame(0, 12'hFFF, 0);   // R7: shows A5C0
    run_frame(0, 12'h000, 30);  // R8: abort in conversion, shows FFF0
    run_frame(0, 12'h123, 0);   // R9: invalid, still FFF0
    run_frame(2, 12'h7E1, 0);   // R3: cs fall with fs low, shows 1230
    run_frame(1, 12'h3C9, 10);  // R3 R8: fs start, abort in shift
    run_frame(1, 12'h000, 0);   // R9: invalid, 7E10
    run_frame(1, 12'h5A5, 0);   // R9 clear, R11: shows 0000
    run_frame(1, 12'hFFF, 0);   // shows 5A50
    run_frame(0, 12'h000, 0);   // R11: shows FFF0
    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    chk(!sdo_oe && pdn, "R5", "idle between frames", {sdo_oe, pdn}, 2'b01);

    if (!wd_hit) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule